// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block reproduces what a host sees when it reads a NOR flash device while the device runs an internal program or erase operation. It keeps the operation mode, a timeout flag, a mask that marks the sectors being erased, and bit 7 of the byte being programmed. Each read strobe returns one of two things. It is either the word from a behavioural storage array, or a status byte that carries the data-poll, toggle, time-limit, erase-active and sector-toggle bits.

The status answer depends on the address. A read that falls in a sector being erased toggles the sector-toggle bit. While an erase is suspended, a read from a sector that is not being erased returns real array data, and a read from an erasing sector returns suspend status. The operation starts, suspend and resume requests, completion and timeout all arrive as single-cycle control pulses. Command decoding and cell timing are left to the surrounding model.

Top module: `flash_status_responder`

## Requirements
- R1: After reset the block is idle and `rd_vld` and `rd_data` are 0. An idle read returns `arr_data` for the address driven on `arr_addr` (= `rd_addr`).
- R2: `rd_vld` pulses for exactly one cycle, in the cycle after a rising edge of `rd_stb`. A strobe held high for several clocks produces one pulse and advances the toggle bits once.
- R3: While programming, status bit 7 is the complement of `prog_poll_bit`, which is captured with `prog_start`. The capture counts as the final write pulse, and the next read already reports status. After `op_done`, reads return array data.
- R4: While erasing, status bit 7 is 0 and bit 3 is 1. While programming, bit 3 is 0.
- R5: Bit 6 is 0 on the first status read after an accepted start. It inverts on every later status read during program, erase and program-in-suspend.
- R6: Bit 2 inverts on successive status reads whose sector (the top 3 address bits) is marked in the erase mask. It reads 1 for unmarked sectors during erase and during program.
- R7: `susp_req` during an erase that has not timed out enters suspend. A suspend read from an unmarked sector returns array data. A suspend read from a marked sector returns bit7=1, bit6=1, bit5=0, bit3=0, with bit 2 toggling. `resume_req` returns to erase.
- R8: `prog_start` during suspend starts a program. Its status follows R3 and R5, with bit 3 = 0 and bit 2 as in R6. `op_done` returns to suspend.
- R9: `op_tmo` during program, erase or program-in-suspend sets bit 5 to 1. Bits 7, 6 and 3 keep their behaviour. Bit 5 is 0 otherwise, and `op_done` clears the timeout.
- R10: Status bits 0, 1 and 4 read 0.
- R11: `op_done` during an erase clears the erase mask and returns to idle, after which reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Read strobe, acted on at its rising edge |
| rd_addr | input | ADDR_W | Read address |
| arr_addr | output | ADDR_W | Address to the behavioural storage |
| arr_data | input | DATA_W | Storage word for `arr_addr` |
| rd_data | output | DATA_W | Registered read result |
| rd_vld | output | 1 | One-cycle result-valid pulse |
| prog_start | input | 1 | Start a program (idle or suspend) |
| prog_poll_bit | input | 1 | Bit 7 of the byte being programmed |
| erase_start | input | 1 | Start an erase (idle only) |
| erase_mask | input | 2**SECT_BITS | Sectors to erase |
| susp_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume the suspended erase |
| op_done | input | 1 | Current operation finished |
| op_tmo | input | 1 | Current operation exceeded its time limit |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=8 and SECT_BITS=3, so there are eight sectors of eight words each. At this size every address can be swept in every mode. The erase mask is chosen to cover both marked and unmarked sectors, so each sweep sees bit 2 toggle on some reads and hold at 1 on others. Array words are computed arithmetically from the address, which separates array data from status in suspend reads.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [2:0] {
      M_IDLE  = 3'd0,
      M_PROG  = 3'd1,
      M_ERASE = 3'd2,
      M_SUSP  = 3'd3,
      M_SPROG = 3'd4
   } fsr_mode_e;

   // status byte bit positions
   localparam int B_POLL = 7;
   localparam int B_TOG  = 6;
   localparam int B_TMO  = 5;
   localparam int B_ERS  = 3;
   localparam int B_SEC  = 2;
endpackage

// File: rtl/fsr_mode_ctrl.sv
module fsr_mode_ctrl
   import fsr_pkg::*;
#(
   parameter int NUM_SECT = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_start,
   input  logic                prog_poll_bit,
   input  logic                erase_start,
   input  logic [NUM_SECT-1:0] erase_mask,
   input  logic                susp_req,
   input  logic                resume_req,
   input  logic                op_done,
   input  logic                op_tmo,
   output fsr_mode_e           mode,
   output logic                tmo,
   output logic                poll_bit,
   output logic [NUM_SECT-1:0] mask,
   output logic                start_acc
);
   fsr_mode_e mode_d;
   logic      tmo_d, busy;

   assign busy = (mode == M_PROG) || (mode == M_ERASE) || (mode == M_SPROG);
   assign start_acc = (prog_start && (mode == M_IDLE || mode == M_SUSP)) ||
                      (erase_start && mode == M_IDLE && !prog_start);

   always_comb begin
      mode_d = mode;
      tmo_d  = tmo;
      if (busy && op_tmo) tmo_d = 1'b1;
      unique case (mode)
         M_IDLE:  if (prog_start) mode_d = M_PROG;
                  else if (erase_start) mode_d = M_ERASE;
         M_PROG:  if (op_done) mode_d = M_IDLE;
         M_ERASE: if (op_done) mode_d = M_IDLE;
                  else if (susp_req && !tmo) mode_d = M_SUSP;
         M_SUSP:  if (prog_start) mode_d = M_SPROG;
                  else if (resume_req) mode_d = M_ERASE;
         M_SPROG: if (op_done) mode_d = M_SUSP;
         default: mode_d = M_IDLE;
      endcase
      if (op_done || start_acc) tmo_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= M_IDLE;
         tmo      <= 1'b0;
         poll_bit <= 1'b0;
      end else begin
         mode <= mode_d;
         tmo  <= tmo_d;
         if (prog_start && (mode == M_IDLE || mode == M_SUSP)) poll_bit <= prog_poll_bit;
      end
   end

   // one register per sector
   for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
      always_ff @(posedge clk) begin
         if (!rst_n) mask[s] <= 1'b0;
         else if (mode == M_ERASE && op_done) mask[s] <= 1'b0;
         else if (mode == M_IDLE && erase_start && !prog_start) mask[s] <= erase_mask[s];
      end
   end

   p_tmo_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> (mode == M_PROG || mode == M_ERASE || mode == M_SPROG));
   p_susp_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_SUSP && $past(mode) != M_SUSP) |-> ($past(mode) == M_ERASE || $past(mode) == M_SPROG));
   p_mask_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == M_IDLE && $past(mode) == M_ERASE) |-> (mask == '0));
endmodule

// File: rtl/fsr_toggle.sv
module fsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic stat_rd,
   input  logic tog_en,
   input  logic hit,
   output logic t6,
   output logic t2
);
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         t6 <= 1'b0;
         t2 <= 1'b0;
      end else if (stat_rd) begin
         if (tog_en) t6 <= ~t6;
         if (hit)    t2 <= ~t2;
      end
   end

   p_t6_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && !clr) |=> $stable(t6));
   p_t2_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!(stat_rd && hit) && !clr) |=> $stable(t2));
endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
   import fsr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  fsr_mode_e         mode,
   input  logic              tmo,
   input  logic              poll_bit,
   input  logic              t6,
   input  logic              t2,
   input  logic              hit,
   input  logic [DATA_W-1:0] arr_data,
   output logic              stat_sel,
   output logic              tog_en,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] st;

   always_comb begin
      st       = '0;
      stat_sel = 1'b1;
      tog_en   = 1'b1;
      unique case (mode)
         M_PROG, M_SPROG: begin
            st[B_POLL] = ~poll_bit;
            st[B_TOG]  = t6;
            st[B_TMO]  = tmo;
            st[B_SEC]  = hit ? t2 : 1'b1;
         end
         M_ERASE: begin
            st[B_TOG]  = t6;
            st[B_TMO]  = tmo;
            st[B_ERS]  = 1'b1;
            st[B_SEC]  = hit ? t2 : 1'b1;
         end
         M_SUSP: begin
            tog_en     = 1'b0;
            stat_sel   = hit;
            st[B_POLL] = 1'b1;
            st[B_TOG]  = 1'b1;
            st[B_SEC]  = t2;
         end
         default: stat_sel = 1'b0;
      endcase
      dout = stat_sel ? st : arr_data;
   end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
   import fsr_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int DATA_W    = 8,
   parameter int SECT_BITS = 3,
   localparam int NUM_SECT = 1 << SECT_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_stb,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [ADDR_W-1:0]   arr_addr,
   input  logic [DATA_W-1:0]   arr_data,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_vld,
   input  logic                prog_start,
   input  logic                prog_poll_bit,
   input  logic                erase_start,
   input  logic [NUM_SECT-1:0] erase_mask,
   input  logic                susp_req,
   input  logic                resume_req,
   input  logic                op_done,
   input  logic                op_tmo
);
   if (DATA_W < 8) begin : g_bad_dw
      $error("DATA_W must be at least 8");
   end
   if (SECT_BITS < 1 || SECT_BITS > ADDR_W) begin : g_bad_sb
      $error("SECT_BITS must lie in 1..ADDR_W");
   end

   fsr_mode_e         mode;
   logic              tmo, poll_bit, start_acc;
   logic [NUM_SECT-1:0] mask;
   logic              stb_q, rd_edge, hit, stat_sel, tog_en, t6, t2;
   logic [DATA_W-1:0] dout;

   assign arr_addr = rd_addr;
   assign rd_edge  = rd_stb && !stb_q;
   assign hit      = mask[rd_addr[ADDR_W-1 -: SECT_BITS]];

   fsr_mode_ctrl #(.NUM_SECT(NUM_SECT)) u_ctrl (
      .clk, .rst_n, .prog_start, .prog_poll_bit, .erase_start, .erase_mask,
      .susp_req, .resume_req, .op_done, .op_tmo,
      .mode, .tmo, .poll_bit, .mask, .start_acc);

   fsr_toggle u_tog (
      .clk, .rst_n, .clr(start_acc), .stat_rd(rd_edge && stat_sel),
      .tog_en, .hit, .t6, .t2);

   fsr_status_mux #(.DATA_W(DATA_W)) u_mux (
      .mode, .tmo, .poll_bit, .t6, .t2, .hit, .arr_data,
      .stat_sel, .tog_en, .dout);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_q   <= 1'b0;
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else begin
         stb_q  <= rd_stb;
         rd_vld <= rd_edge;
         if (rd_edge) rd_data <= dout;
      end
   end

   p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |=> !rd_vld);
   p_erase_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && $past(mode == M_ERASE)) |-> (!rd_data[B_POLL] && rd_data[B_ERS]));
   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld && $past(stat_sel)) |-> (rd_data[1:0] == 2'b00 && !rd_data[4]));
endmodule

// File: tb/flash_status_responder_test.sv
module flash_status_responder_test;
   localparam int AW = 6, DW = 8, SB = 3, NS = 8;
   localparam int IDLE = 0, PROG = 1, ERASE = 2, SUSP = 3, SPROG = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rd_stb = 1'b0;
   logic [AW-1:0] rd_addr = '0, arr_addr;
   logic [DW-1:0] arr_data, rd_data;
   logic rd_vld;
   logic prog_start = 0, prog_poll_bit = 0, erase_start = 0;
   logic [NS-1:0] erase_mask = '0;
   logic susp_req = 0, resume_req = 0, op_done = 0, op_tmo = 0;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   // bench model of the specified behaviour
   int m_mode = IDLE;
   bit m_tmo = 0, m_poll = 0, m_t6 = 0, m_t2 = 0;
   logic [NS-1:0] m_mask = '0;

   always #4 clk = ~clk;

   function automatic logic [DW-1:0] arr_f(input logic [AW-1:0] a);
      return 8'((a * 37) ^ 8'h5A);
   endfunction
   assign arr_data = arr_f(arr_addr);

   flash_status_responder #(.ADDR_W(AW), .DATA_W(DW), .SECT_BITS(SB)) uut (
      .clk, .rst_n, .rd_stb, .rd_addr, .arr_addr, .arr_data, .rd_data, .rd_vld,
      .prog_start, .prog_poll_bit, .erase_start, .erase_mask, .susp_req,
      .resume_req, .op_done, .op_tmo);

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // expected read value, then model toggle update
   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      logic [DW-1:0] r;
      bit h, st;
      h  = m_mask[a[AW-1:AW-SB]];
      st = 1;
      r  = '0;
      case (m_mode)
         PROG, SPROG: begin r[7] = ~m_poll; r[6] = m_t6; r[5] = m_tmo; r[2] = h ? m_t2 : 1'b1; end
         ERASE: begin r[6] = m_t6; r[5] = m_tmo; r[3] = 1; r[2] = h ? m_t2 : 1'b1; end
         SUSP: if (h) begin r[7] = 1; r[6] = 1; r[2] = m_t2; end
               else begin st = 0; r = arr_f(a); end
         default: begin st = 0; r = arr_f(a); end
      endcase
      if (st) begin
         if (m_mode != SUSP) m_t6 = ~m_t6;
         if (h) m_t2 = ~m_t2;
      end
      return r;
   endfunction

   task automatic do_read(input logic [AW-1:0] a, input string req);
      logic [DW-1:0] e;
      @(negedge clk);
      rd_addr = a; rd_stb = 1;
      e = model_read(a);
      @(negedge clk);
      check({req, " vld"}, {7'd0, rd_vld}, 8'd1);
      check(req, rd_data, e);
      rd_stb = 0;
      @(negedge clk);
   endtask

   task automatic sweep(input string req);
      for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), req);
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1;
      @(negedge clk); sig = 0;
   endtask

   task automatic start_prog(input bit pb);
      prog_poll_bit = pb;
      pulse(prog_start);
      m_mode = (m_mode == SUSP) ? SPROG : PROG;
      m_poll = pb; m_tmo = 0; m_t6 = 0; m_t2 = 0;
   endtask

   task automatic finish_op();
      pulse(op_done);
      m_tmo = 0;
      if (m_mode == SPROG) m_mode = SUSP;
      else begin
         if (m_mode == ERASE) m_mask = '0;
         m_mode = IDLE;
      end
   endtask

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 vld", {7'd0, rd_vld}, 8'd0);
      check("R1 data", rd_data, 8'd0);
      rst_n = 1;
      @(negedge clk);
      sweep("R1 idle");

      // R3, R5, R6, R10: program with poll bit 1 -> bit7 reads 0
      start_prog(1'b1);
      for (int a = 0; a < 16; a++) do_read(AW'(a * 5), "R3/R5/R6/R10 prog");

      // R2: held strobe -> one pulse, one toggle advance
      @(negedge clk);
      rd_addr = 6'd9; rd_stb = 1;
      void'(model_read(6'd9));
      pulses = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         pulses += int'(rd_vld);
      end
      rd_stb = 0;
      @(negedge clk);
      check("R2 pulses", 8'(pulses), 8'd1);
      do_read(6'd9, "R2 toggle after hold");

      // R9: timeout during program
      pulse(op_tmo); m_tmo = 1;
      for (int a = 0; a < 6; a++) do_read(AW'(a), "R9 prog tmo");
      finish_op();
      for (int a = 0; a < 8; a++) do_read(AW'(a * 7), "R3 after done");

      // poll bit 0 -> bit7 reads 1
      start_prog(1'b0);
      for (int a = 0; a < 6; a++) do_read(AW'(a + 40), "R3/R5 prog0");
      finish_op();

      // R4, R6: erase of sectors 0,2,5,7
      erase_mask = 8'b1010_0101;
      pulse(erase_start);
      m_mode = ERASE; m_mask = 8'b1010_0101; m_t6 = 0; m_t2 = 0; m_tmo = 0;
      sweep("R4/R5/R6 erase");
      sweep("R4/R6 erase second");

      // R7: suspend
      pulse(susp_req); m_mode = SUSP;
      sweep("R7 suspend");

      // R8: program during suspend
      start_prog(1'b1);
      sweep("R8 susp prog");
      pulse(op_tmo); m_tmo = 1;
      for (int a = 0; a < 12; a++) do_read(AW'(a * 5), "R8/R9 susp prog tmo");
      finish_op();
      sweep("R8 back to suspend");

      // R7: resume
      pulse(resume_req); m_mode = ERASE;
      sweep("R7 resume erase");

      // R9: erase timeout, suspend ignored while timed out
      pulse(op_tmo); m_tmo = 1;
      pulse(susp_req);
      sweep("R9 erase tmo");

      // R11: erase done
      finish_op();
      sweep("R11 idle after erase");

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule